// File: doc/BRIEF.md
# Externally Clocked Serial Result Readout with Daisy-Chain Pass-Through

This block delivers the last completed conversion word of a sampling converter over a one-wire serial output, paced by a data clock that the host supplies. A read opens when the chip-select and read/convert controls together enter the read condition. The word then leaves most significant bit first, one bit per rising edge of the host clock. If the host clock has been running while no read was open, the block first raises a one-period synchronisation pulse, so the host can find the word boundary.

After the last data bit, the output keeps shifting bits taken from a tag input for as long as the read stays open. The first of these bits is the tag level captured when the read opened. Several converters can therefore be chained: each data output feeds the tag input of the next device, and a null separator bit falls between the words. All logic runs on one system clock. The host data clock, chip select and read/convert are sampled in that domain, and the block acts on the rising edges it detects there.

The controller has four states. ST_IDLE is used while no read is open. ST_SYNC_WAIT is a read that is armed for a sync pulse and is waiting for its first clock edge. ST_SYNC_HIGH holds the sync pulse until the next clock edge. ST_SHIFT moves data and then tag bits. The transitions are:
- Any state goes to ST_IDLE when the read condition goes away.
- ST_IDLE goes to ST_SYNC_WAIT on a read start when the block is armed, and to ST_SHIFT on a read start when it is not armed.
- ST_SYNC_WAIT goes to ST_SYNC_HIGH on a rising clock edge.
- ST_SYNC_HIGH goes to ST_SHIFT on the next rising edge, and that edge also shifts out the MSB.

Top module: `chain_readout`

## Requirements
- R1: After reset, `sdata` and `sync` are both 0.
- R2: A read opens when `rc` rises while `cs_n` is already low.
- R3: A read opens when `cs_n` falls while `rc` is already high. The read condition is `cs_n` low and `rc` high.
- R4: When armed, the first rising `dclk` edge of a read sets `sync` to 1 and leaves `sdata` unchanged. The next rising edge clears `sync` and puts the MSB on `sdata`. `sync` stays high between these two edges.
- R5: When not armed, no sync pulse is made, and the first rising `dclk` edge of the read puts the MSB on `sdata`.
- R6: Shifting edges send the word out MSB first, one bit per rising `dclk` edge: after shifting edge k (1..16), `sdata` equals word bit 16-k.
- R7: After shifting edge 17, `sdata` equals the `tag` level sampled when the read opened (the null bit). After shifting edge k ≥ 18, `sdata` equals the `tag` level sampled at shifting edge k-17.
- R8: The word sent is the `conv_word` of the latest `conv_done` pulse before the read opened. A `conv_done` during an open read does not change the bits of that read.
- R9: While the read condition is absent, `dclk` edges do not change `sdata`, and `sync` is 0.
- R10: The block becomes armed on a rising `dclk` edge seen while no read is open. Every read start disarms it, so a read with no such edge since the previous read start has no sync pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dclk | input | 1 | Host-supplied data clock, sampled on clk |
| cs_n | input | 1 | Chip select, active low |
| rc | input | 1 | Read/convert control; high with cs_n low is the read condition |
| tag | input | 1 | Serial input from the previous device in the chain |
| conv_done | input | 1 | One-cycle pulse: a conversion result is ready |
| conv_word | input | 16 | Result word, valid with conv_done |
| sdata | output | 1 | Serial data output |
| sync | output | 1 | Synchronisation pulse before the word |

## Verification
Reads are opened in both ways: by an `rc` rise under a low `cs_n`, and by a `cs_n` fall under a high `rc`. This shows that the two triggers are equivalent. Some reads start after a silent clock and some after clock pulses sent outside a read. This separates the sync path from the direct-MSB path and shows the re-arming rule. The tag input follows a period-three pattern that is different from the level held at read start. This tells the null bit apart from a pass-through with the wrong latency. A read aborted partway, and a new result loaded during an open read, show that shifting freezes outside a read and that the word is captured when the read opens.

// File: rtl/chain_pkg.sv
package chain_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC_WAIT,
        ST_SYNC_HIGH,
        ST_SHIFT
    } rd_state_t;
endpackage

// File: rtl/xclk_rise_det.sv
module xclk_rise_det (
    input  logic clk,
    input  logic rst,
    input  logic lvl_i,
    output logic rise_o
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/read_gate.sv
module read_gate (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic rc,
    output logic active_o,
    output logic start_o
);
    logic active_q;

    assign active_o = ~cs_n & rc;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active_o;
    end

    // Entering the read condition covers both the rc-rise and cs_n-fall triggers
    assign start_o = active_o & ~active_q;
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              tag_i,
    input  logic              shift_i,
    output logic              bit_o
);
    localparam int CHAIN_W = WORD_W + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            out_q   <= 1'b0;
        end else if (load_i) begin
            // Extra low stage keeps the tag level seen at read start: the null bit
            chain_q <= {word_i, tag_i};
        end else if (shift_i) begin
            out_q   <= chain_q[CHAIN_W-1];
            chain_q <= {chain_q[CHAIN_W-2:0], tag_i};
        end
    end

    assign bit_o = out_q;
endmodule

// File: rtl/chain_readout.sv
module chain_readout
    import chain_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dclk,
    input  logic              cs_n,
    input  logic              rc,
    input  logic              tag,
    input  logic              conv_done,
    input  logic [WORD_W-1:0] conv_word,
    output logic              sdata,
    output logic              sync
);
    rd_state_t         state_q, state_d;
    logic              dclk_rise, rd_active, rd_start;
    logic              armed_q, sync_q, shift_en;
    logic [WORD_W-1:0] last_word_q, word_sel;

    xclk_rise_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .lvl_i (dclk),
        .rise_o(dclk_rise)
    );

    read_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .rc      (rc),
        .active_o(rd_active),
        .start_o (rd_start)
    );

    always_ff @(posedge clk) begin
        if (rst)            last_word_q <= '0;
        else if (conv_done) last_word_q <= conv_word;
    end

    assign word_sel = conv_done ? conv_word : last_word_q;

    // Arming: any clock edge seen while no read is open
    always_ff @(posedge clk) begin
        if (rst)                          armed_q <= 1'b0;
        else if (rd_start)                armed_q <= 1'b0;
        else if (!rd_active && dclk_rise) armed_q <= 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!rd_active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:      if (rd_start)  state_d = armed_q ? ST_SYNC_WAIT : ST_SHIFT;
                ST_SYNC_WAIT: if (dclk_rise) state_d = ST_SYNC_HIGH;
                ST_SYNC_HIGH: if (dclk_rise) state_d = ST_SHIFT;
                ST_SHIFT:                    state_d = ST_SHIFT;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst || !rd_active) begin
            sync_q <= 1'b0;
        end else if (dclk_rise) begin
            if (state_q == ST_SYNC_WAIT)      sync_q <= 1'b1;
            else if (state_q == ST_SYNC_HIGH) sync_q <= 1'b0;
        end
    end

    assign shift_en = rd_active && dclk_rise &&
                      ((state_q == ST_SHIFT) || (state_q == ST_SYNC_HIGH));

    word_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load_i (rd_start),
        .word_i (word_sel),
        .tag_i  (tag),
        .shift_i(shift_en),
        .bit_o  (sdata)
    );

    assign sync = sync_q;
endmodule

// File: rtl/chain_readout_chk.sv
module chain_readout_chk (
    input logic clk,
    input logic rst,
    input logic dclk,
    input logic cs_n,
    input logic rc,
    input logic sdata,
    input logic sync
);
    logic dclk_prev, act_prev, rise_now, act_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            dclk_prev <= 1'b0;
            act_prev  <= 1'b0;
        end else begin
            dclk_prev <= dclk;
            act_prev  <= act_now;
        end
    end

    assign act_now  = ~cs_n & rc;
    assign rise_now = dclk & ~dclk_prev;

    // R4: sync only follows an open read
    p_sync_in_read_r4: assert property (@(posedge clk) disable iff (rst)
        sync |-> act_prev);

    // R4: sync lasts until the next clock edge, then drops
    p_sync_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (sync && act_now && !rise_now) |=> sync);

    p_sync_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (sync && act_now && rise_now) |=> !sync);

    // R9: output moves only on a clock edge inside a read
    p_hold_outside_r9: assert property (@(posedge clk) disable iff (rst)
        !(act_now && rise_now) |=> $stable(sdata));

    // R9: leaving the read clears sync
    p_exit_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !act_now |=> !sync);
endmodule

bind chain_readout chain_readout_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .dclk (dclk),
    .cs_n (cs_n),
    .rc   (rc),
    .sdata(sdata),
    .sync (sync)
);

// File: tb/tb_chain_readout.sv
module tb_chain_readout;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        rc = 1'b0;
    logic        tag = 1'b0;
    logic        conv_done = 1'b0;
    logic [15:0] conv_word = '0;
    logic        sdata, sync;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    logic taghist [0:63];

    always #5 clk = ~clk;

    chain_readout dut (
        .clk(clk), .rst(rst), .dclk(dclk), .cs_n(cs_n), .rc(rc), .tag(tag),
        .conv_done(conv_done), .conv_word(conv_word), .sdata(sdata), .sync(sync)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic tv);
        @(negedge clk);
        tag  = tv;
        dclk = 1'b1;
        repeat (3) @(negedge clk);
        dclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic load_word(input logic [15:0] w);
        @(negedge clk);
        conv_word = w;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 sdata", {15'd0, sdata}, 16'd0);
        chk("R1 sync", {15'd0, sync}, 16'd0);
    endtask

    // Read opened by rc rise, no prior clock: no sync, word then tag stream
    task automatic t_read_nosync();
        logic tv;
        load_word(16'hA5C3);
        @(negedge clk);
        cs_n = 1'b0;
        tag  = 1'b1;
        @(negedge clk);
        rc = 1'b1;                // R2 trigger
        repeat (2) @(negedge clk);
        for (int k = 1; k <= 20; k++) begin
            tv = (k % 3 == 0);
            taghist[k] = tv;
            pulse(tv);
            chk("R5 no sync", {15'd0, sync}, 16'd0);
            if (k <= 16)       chk("R6 R2 data bit", {15'd0, sdata}, {15'd0, 16'hA5C3 >> (16 - k)} & 16'd1);
            else if (k == 17)  chk("R7 null bit", {15'd0, sdata}, 16'd1);
            else               chk("R7 tag pass", {15'd0, sdata}, {15'd0, taghist[k-17]});
        end
        @(negedge clk);
        rc = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Clock pulses outside a read: output frozen, block arms
    task automatic t_idle_pulses();
        logic keep;
        keep = sdata;
        for (int k = 0; k < 3; k++) begin
            pulse(k[0]);
            chk("R9 hold outside", {15'd0, sdata}, {15'd0, keep});
            chk("R9 sync low", {15'd0, sync}, 16'd0);
        end
    endtask

    // Read opened by cs_n fall with sync, mid-read load, then abort
    task automatic t_read_sync_abort();
        logic keep;
        load_word(16'h3C96);
        @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        rc = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b0;              // R3 trigger
        repeat (2) @(negedge clk);
        keep = sdata;
        pulse(1'b0);
        chk("R4 sync high", {15'd0, sync}, 16'd1);
        chk("R4 data unchanged", {15'd0, sdata}, {15'd0, keep});
        repeat (4) @(negedge clk);
        chk("R4 sync held", {15'd0, sync}, 16'd1);
        for (int k = 1; k <= 9; k++) begin
            if (k == 6) load_word(16'h0F0F);
            pulse(1'b0);
            if (k == 1) chk("R4 sync drop", {15'd0, sync}, 16'd0);
            chk("R3 R8 data bit", {15'd0, sdata}, {15'd0, 16'h3C96 >> (16 - k)} & 16'd1);
        end
        keep = sdata;
        @(negedge clk);
        cs_n = 1'b1;              // leave read
        repeat (3) @(negedge clk);
        chk("R9 sync after exit", {15'd0, sync}, 16'd0);
        chk("R9 data after exit", {15'd0, sdata}, {15'd0, keep});
    endtask

    // New read with no edge since last read start: no sync, new word
    task automatic t_read_rearm();
        @(negedge clk);
        rc = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        rc = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 1; k <= 16; k++) begin
            pulse(1'b1);
            chk("R10 no sync", {15'd0, sync}, 16'd0);
            chk("R8 new word bit", {15'd0, sdata}, {15'd0, 16'h0F0F >> (16 - k)} & 16'd1);
        end
        @(negedge clk);
        rc = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_nosync();
        t_idle_pulses();
        t_read_sync_abort();
        t_read_rearm();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule